// File: doc/BRIEF.md
# Blanking-Start to Scrambler-Reset Substitution Unit

This unit sits in a DisplayPort link-layer symbol path. It registers one 9-bit symbol per clock, written as {K flag, byte}. It decides which blanking-start (BS) control symbols leave the link as scrambler-reset (SR) symbols instead. Each SR it sends comes with a one-cycle scrambler-reset pulse, so the downstream scrambler can re-seed on the same symbol.

In active mode, symbols pass through and the upstream framer marks each BS with a flag. In idle mode, the unit ignores the incoming stream and produces its own idle filler. It places a BS at a programmable period inside that filler. A periodic swap count turns every (N+1)th BS into an SR, counted since the last SR. A count of zero swaps every BS. A one-shot path gives fast link re-entry after a power-save exit. A start strobe arms it, it lets a programmed number of BS symbols through, and then it forces the next BS to SR exactly once.

Top module: `bs_sr_swapper`

## Requirements
- R1: While reset is asserted, `symOut` is 9'h000 and `srPulse` is 0. The one-shot path is disarmed and all counters are zero.
- R2: In active mode (`idleMode`=0), a symbol without `bsMark` appears unchanged on `symOut` one clock later, with `srPulse`=0.
- R3: In idle mode, the first idle cycle and every `idleInterval`th cycle after it emit BS (9'h1BC). All other idle cycles emit filler (9'h000). An interval of 0 or 1 emits BS on every cycle.
- R4: With `swapCount`=N>0, the BS that arrives after N BS symbols have passed since the last SR is emitted as SR (9'h11C). The preceding BS symbols pass unchanged.
- R5: With `swapCount`=0, every BS is emitted as SR.
- R6: A one-cycle `loadStart` arms the one-shot path and clears its count. `loadCount` BS symbols then pass, and the next BS is emitted as SR.
- R7: After its SR, the one-shot path disarms and forces no further SR until `loadStart` is pulsed again.
- R8: `srPulse` is high in exactly the cycles in which `symOut` carries a substituted SR, and only after a BS slot.
- R9: Any SR, periodic or one-shot, restarts the periodic BS count from zero.
- R10: When the periodic and one-shot conditions fall on the same BS, a single SR is produced and both conditions are consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rstN | input | 1 | Active-low synchronous reset |
| symIn | input | 9 | Incoming symbol {K, byte} |
| bsMark | input | 1 | Marks `symIn` as a BS symbol (active mode) |
| idleMode | input | 1 | 1: emit generated idle stream; 0: pass `symIn` |
| idleInterval | input | 16 | Symbol periods between generated BS symbols |
| swapCount | input | 9 | Periodic swap count |
| loadCount | input | 8 | BS symbols to let pass before the one-shot SR |
| loadStart | input | 1 | One-cycle strobe arming the one-shot SR |
| symOut | output | 9 | Outgoing symbol, one cycle after input |
| srPulse | output | 1 | High with each substituted SR symbol |

## Verification
A wrong periodic count shows up at the SR position: the SR arrives one or more BS symbols early or late, or is missing after a one-shot SR has cleared the count. This is visible within a handful of BS slots once the swap count is small. A one-shot path that stays armed or fires twice shows as an extra SR on a later BS. An idle-period counter that is off by one moves every generated BS by a cycle, which is visible on the second BS of the idle stream. Scenarios therefore use small counts, so that every misplaced substitution appears within tens of cycles.

// File: rtl/bssr_pkg.sv
package bssr_pkg;
  // Strobes from control to datapath for the current input slot
  typedef struct packed {
    logic bsNow;     // this slot is a BS candidate
    logic makeSr;    // replace this BS by SR
    logic genSlot;   // datapath emits generated idle stream
  } symCtl_t;
endpackage

// File: rtl/bssr_ctrl.sv
module bssr_ctrl
  import bssr_pkg::*;
#(
  parameter int IDLE_W = 16,
  parameter int SWAP_W = 9,
  parameter int LOAD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bsMark,
  input  logic              idleMode,
  input  logic [IDLE_W-1:0] idleInterval,
  input  logic [SWAP_W-1:0] swapCount,
  input  logic [LOAD_W-1:0] loadCount,
  input  logic              loadStart,
  output symCtl_t           ctl
);
  localparam int IDLE_XW = IDLE_W + 1;

  logic [IDLE_W-1:0] idleCnt;
  logic [SWAP_W-1:0] bsCnt;
  logic [LOAD_W-1:0] oneCnt;
  logic              armed;

  logic bsNow, periodicHit, oneHit, makeSr, idleWrap;
  logic [IDLE_XW-1:0] idleNext;

  always_comb begin
    bsNow       = idleMode ? (idleCnt == '0) : bsMark;
    // >= keeps the swap safe when the count is lowered mid-run; 0 swaps all
    periodicHit = bsNow && (bsCnt >= swapCount);
    oneHit      = bsNow && armed && (oneCnt >= loadCount);
    makeSr      = periodicHit || oneHit;
    idleNext    = {1'b0, idleCnt} + IDLE_XW'(1);
    idleWrap    = idleNext >= {1'b0, idleInterval};
    ctl.bsNow   = bsNow;
    ctl.makeSr  = makeSr;
    ctl.genSlot = idleMode;
  end

  // Idle BS period counter
  always_ff @(posedge clk) begin
    if (!rstN)          idleCnt <= '0;
    else if (!idleMode) idleCnt <= '0;
    else if (idleWrap)  idleCnt <= '0;
    else                idleCnt <= idleNext[IDLE_W-1:0];
  end

  // Periodic BS count, restarted by any SR
  always_ff @(posedge clk) begin
    if (!rstN)       bsCnt <= '0;
    else if (makeSr) bsCnt <= '0;
    else if (bsNow)  bsCnt <= bsCnt + SWAP_W'(1);
  end

  // One-shot forced SR
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed  <= 1'b0;
      oneCnt <= '0;
    end else if (loadStart) begin
      armed  <= 1'b1;
      oneCnt <= '0;
    end else if (oneHit) begin
      armed  <= 1'b0;
      oneCnt <= '0;
    end else if (armed && bsNow) begin
      oneCnt <= oneCnt + LOAD_W'(1);
    end
  end
endmodule

// File: rtl/bssr_datapath.sv
module bssr_datapath
  import bssr_pkg::*;
#(
  parameter int             SYM_W     = 9,
  parameter logic [SYM_W-1:0] BS_CODE   = 9'h1BC,
  parameter logic [SYM_W-1:0] SR_CODE   = 9'h11C,
  parameter logic [SYM_W-1:0] IDLE_CODE = 9'h000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SYM_W-1:0] symIn,
  input  symCtl_t          ctl,
  output logic [SYM_W-1:0] symOut,
  output logic             srPulse
);
  logic [SYM_W-1:0] symNext;

  always_comb begin
    if (ctl.makeSr)                   symNext = SR_CODE;
    else if (ctl.genSlot && ctl.bsNow) symNext = BS_CODE;
    else if (ctl.genSlot)              symNext = IDLE_CODE;
    else                               symNext = symIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      symOut  <= '0;
      srPulse <= 1'b0;
    end else begin
      symOut  <= symNext;
      srPulse <= ctl.makeSr;
    end
  end
endmodule

// File: rtl/bs_sr_swapper.sv
module bs_sr_swapper
  import bssr_pkg::*;
#(
  parameter int SYM_W  = 9,
  parameter int IDLE_W = 16,
  parameter int SWAP_W = 9,
  parameter int LOAD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SYM_W-1:0]  symIn,
  input  logic              bsMark,
  input  logic              idleMode,
  input  logic [IDLE_W-1:0] idleInterval,
  input  logic [SWAP_W-1:0] swapCount,
  input  logic [LOAD_W-1:0] loadCount,
  input  logic              loadStart,
  output logic [SYM_W-1:0]  symOut,
  output logic              srPulse
);
  symCtl_t ctl;

  bssr_ctrl #(.IDLE_W(IDLE_W), .SWAP_W(SWAP_W), .LOAD_W(LOAD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .bsMark(bsMark), .idleMode(idleMode),
    .idleInterval(idleInterval), .swapCount(swapCount),
    .loadCount(loadCount), .loadStart(loadStart), .ctl(ctl)
  );

  bssr_datapath #(.SYM_W(SYM_W)) u_dp (
    .clk(clk), .rstN(rstN), .symIn(symIn), .ctl(ctl),
    .symOut(symOut), .srPulse(srPulse)
  );
endmodule

// File: rtl/bs_sr_swapper_chk.sv
module bs_sr_swapper_chk #(
  parameter int SYM_W  = 9,
  parameter int IDLE_W = 16,
  parameter int SWAP_W = 9,
  parameter int LOAD_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [SYM_W-1:0]  symIn,
  input logic              bsMark,
  input logic              idleMode,
  input logic [IDLE_W-1:0] idleInterval,
  input logic [SWAP_W-1:0] swapCount,
  input logic [LOAD_W-1:0] loadCount,
  input logic              loadStart,
  input logic [SYM_W-1:0]  symOut,
  input logic              srPulse
);
  localparam logic [SYM_W-1:0] BS_V   = 9'h1BC;
  localparam logic [SYM_W-1:0] SR_V   = 9'h11C;
  localparam logic [SYM_W-1:0] IDLE_V = 9'h000;

  // R8
  sr_carries_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    srPulse |-> (symOut == SR_V));

  // R8
  sr_after_bs_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    srPulse |-> $past(idleMode || bsMark));

  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!idleMode && !bsMark) |=> (!srPulse && symOut == $past(symIn)));

  // R5
  swap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!idleMode && bsMark && swapCount == '0) |=> srPulse);

  // R3
  idle_alphabet_chk: assert property (@(posedge clk) disable iff (!rstN)
    idleMode |=> (symOut == IDLE_V || symOut == BS_V || symOut == SR_V));
endmodule

bind bs_sr_swapper bs_sr_swapper_chk #(
  .SYM_W(SYM_W), .IDLE_W(IDLE_W), .SWAP_W(SWAP_W), .LOAD_W(LOAD_W)
) u_chk (
  .clk(clk), .rstN(rstN), .symIn(symIn), .bsMark(bsMark),
  .idleMode(idleMode), .idleInterval(idleInterval), .swapCount(swapCount),
  .loadCount(loadCount), .loadStart(loadStart), .symOut(symOut),
  .srPulse(srPulse)
);

// File: tb/bs_sr_swapper_tb.sv
`timescale 1ns/1ps
module bs_sr_swapper_tb;
  localparam logic [8:0] BS   = 9'h1BC;
  localparam logic [8:0] SR   = 9'h11C;
  localparam logic [8:0] IDLE = 9'h000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [8:0]  symIn = '0;
  logic        bsMark = 1'b0;
  logic        idleMode = 1'b0;
  logic [15:0] idleInterval = 16'd4;
  logic [8:0]  swapCount = 9'h1FF;
  logic [7:0]  loadCount = 8'd5;
  logic        loadStart = 1'b0;
  logic [8:0]  symOut;
  logic        srPulse;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  bs_sr_swapper u_dut (
    .clk(clk), .rstN(rstN), .symIn(symIn), .bsMark(bsMark),
    .idleMode(idleMode), .idleInterval(idleInterval), .swapCount(swapCount),
    .loadCount(loadCount), .loadStart(loadStart), .symOut(symOut),
    .srPulse(srPulse)
  );

  task automatic expectOut(input string req, input logic [8:0] eSym, input logic eSr);
    checks++;
    if (symOut !== eSym || srPulse !== eSr) begin
      fails++;
      $display("FAIL %s: symOut=%h srPulse=%b expected symOut=%h srPulse=%b",
               req, symOut, srPulse, eSym, eSr);
    end
  endtask

  // Drive one slot at the falling edge; return just after the capturing edge
  task automatic drive(input logic [8:0] s, input logic b, input logic ls);
    @(negedge clk);
    symIn = s; bsMark = b; loadStart = ls;
    @(posedge clk);
    #1;
    symIn = '0; bsMark = 1'b0; loadStart = 1'b0;
  endtask

  task automatic resetDut();
    @(negedge clk);
    rstN = 1'b0; idleMode = 1'b0; symIn = '0; bsMark = 1'b0; loadStart = 1'b0;
    @(negedge clk);
    @(negedge clk);
    expectOut("R1 reset", IDLE, 1'b0);
    rstN = 1'b1;
    @(posedge clk);
    #1;
  endtask

  task automatic testPassThrough();
    resetDut();
    swapCount = 9'h1FF;
    drive(9'h0A5, 1'b0, 1'b0); expectOut("R2 data", 9'h0A5, 1'b0);
    drive(9'h155, 1'b0, 1'b0); expectOut("R2 data", 9'h155, 1'b0);
    drive(9'h1FB, 1'b0, 1'b0); expectOut("R2 control", 9'h1FB, 1'b0);
  endtask

  task automatic testIdle();
    resetDut();
    swapCount = 9'h1FF; idleInterval = 16'd4; idleMode = 1'b1;
    for (int i = 0; i < 9; i++) begin
      drive(9'h0F0, 1'b0, 1'b0);
      expectOut("R3 interval 4", (i % 4 == 0) ? BS : IDLE, 1'b0);
    end
    resetDut();
    idleInterval = 16'd1; idleMode = 1'b1;
    for (int i = 0; i < 3; i++) begin
      drive(9'h0F0, 1'b0, 1'b0);
      expectOut("R3 interval 1", BS, 1'b0);
    end
    idleMode = 1'b0;
  endtask

  task automatic testPeriodic();
    resetDut();
    swapCount = 9'd3;
    for (int i = 1; i <= 5; i++) begin
      drive(BS, 1'b1, 1'b0);
      expectOut("R4 periodic", (i == 4) ? SR : BS, i == 4);
      drive(9'h033, 1'b0, 1'b0);
      expectOut("R8 no pulse on data", 9'h033, 1'b0);
    end
  endtask

  task automatic testSwapZero();
    resetDut();
    swapCount = 9'd0;
    for (int i = 0; i < 3; i++) begin
      drive(BS, 1'b1, 1'b0);
      expectOut("R5 swap all", SR, 1'b1);
    end
  endtask

  task automatic testOneShot();
    resetDut();
    swapCount = 9'h1FF; loadCount = 8'd2; idleInterval = 16'd2;
    drive(9'h011, 1'b0, 1'b1);
    expectOut("R6 arm", 9'h011, 1'b0);
    idleMode = 1'b1;
    for (int i = 0; i < 10; i++) begin
      drive(9'h000, 1'b0, 1'b0);
      if (i == 4)          expectOut("R6 forced SR", SR, 1'b1);
      else if (i % 2 == 0) expectOut("R7 no further SR", BS, 1'b0);
      else                 expectOut("R3 filler", IDLE, 1'b0);
    end
    idleMode = 1'b0;
  endtask

  task automatic testCountRestart();
    resetDut();
    swapCount = 9'd3; loadCount = 8'd1;
    drive(BS, 1'b1, 1'b0); expectOut("R9 bs1", BS, 1'b0);
    drive(9'h022, 1'b0, 1'b1); expectOut("R9 arm", 9'h022, 1'b0);
    drive(BS, 1'b1, 1'b0); expectOut("R9 bs2", BS, 1'b0);
    drive(BS, 1'b1, 1'b0); expectOut("R9 one-shot SR", SR, 1'b1);
    for (int i = 4; i <= 7; i++) begin
      drive(BS, 1'b1, 1'b0);
      expectOut("R9 periodic restarted", (i == 7) ? SR : BS, i == 7);
    end
  endtask

  task automatic testCoincide();
    resetDut();
    swapCount = 9'd2; loadCount = 8'd2;
    drive(9'h044, 1'b0, 1'b1); expectOut("R10 arm", 9'h044, 1'b0);
    drive(BS, 1'b1, 1'b0); expectOut("R10 bs1", BS, 1'b0);
    drive(BS, 1'b1, 1'b0); expectOut("R10 bs2", BS, 1'b0);
    drive(BS, 1'b1, 1'b0); expectOut("R10 shared SR", SR, 1'b1);
    drive(9'h055, 1'b0, 1'b0); expectOut("R10 single pulse", 9'h055, 1'b0);
    drive(BS, 1'b1, 1'b0); expectOut("R10 both consumed", BS, 1'b0);
    drive(BS, 1'b1, 1'b0); expectOut("R10 bs5", BS, 1'b0);
    drive(BS, 1'b1, 1'b0); expectOut("R10 next periodic", SR, 1'b1);
  endtask

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    testPassThrough();
    testIdle();
    testPeriodic();
    testSwapZero();
    testOneShot();
    testCountRestart();
    testCoincide();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule